// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks the frame to be evicted when a new page must be brought into a full physical memory. It keeps one reference bit per frame and a hand pointer that walks the frames in a ring. Every access reported on the access port marks the touched frame as recently used. When a replacement is requested, the block looks at one frame per clock, starting at the hand. A frame whose bit is set has its bit cleared and is passed over. The first frame found with a clear bit becomes the victim.

The victim slot then holds the incoming page. That slot's bit is set and the hand moves to the following slot. The next search therefore resumes where this one stopped. A frame that has been passed over is not taken until every other frame has been looked at. Page-table updates and data movement belong to the surrounding logic.

The controller has three states. IDLE waits for a request. SCAN examines the frame under the hand once per cycle. REPORT presents the victim for one cycle. Its transitions are:
- IDLE to SCAN on a request.
- SCAN to SCAN while the examined bit is set.
- SCAN to REPORT when the examined bit is clear.
- REPORT to IDLE unconditionally.

Top module: `clock_victim_sel`

## Requirements
- R1: Reset clears every reference bit, puts the hand on frame 0 and holds `victim_valid` low, so that the first request afterwards selects frame 0 after one examined frame.
- R2: An access (`acc_valid` high with frame index `acc_frame`) sets that frame's reference bit on the next clock edge, in any state.
- R3: A request (`repl_req` high) is taken only in IDLE. From the edge after that, the block examines exactly one frame per clock, beginning at the hand and moving to the next index, with index NUM_FRAMES-1 followed by 0.
- R4: An examined frame whose bit is 1 has its bit cleared and the search continues with the next frame.
- R5: The first examined frame whose bit is 0 is the victim. `victim_valid` is high for exactly one cycle, with `victim_frame` holding its index. The number of clock edges from the request edge to the cycle showing `victim_valid` equals the number of frames examined.
- R6: After a victim is chosen, its reference bit is 1 and the hand points to the following frame.
- R7: If every bit is 1 when a search starts, the search clears all of them in one full lap and selects the frame where it started, after NUM_FRAMES+1 examined frames.
- R8: An access to the frame being examined, in the same cycle that the search would clear its bit, leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access to a resident frame occurred this cycle |
| acc_frame | input | IDX_W | Index of the accessed frame |
| repl_req | input | 1 | Request to choose a victim (taken in IDLE) |
| victim_valid | output | 1 | One-cycle pulse: victim index is valid |
| victim_frame | output | IDX_W | Index of the chosen victim frame |

## Verification
The hardest situation to reach is an access landing on the exact frame the hand is clearing. That clash exists for a single cycle somewhere inside a multi-cycle search. The bench reaches it by filling every bit with accesses first, so the search length is known in advance. It then drives an access to the start frame in the first examined cycle, and checks that the search needs a second pass over that frame and stops one frame later. Hand positions other than 0 can only be reached through earlier replacements. The sweep therefore performs 0 to 7 warm-up replacements before loading each of the 256 bit patterns.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } sel_state_e;
endpackage

// File: rtl/csel_ref_bits.sv
module csel_ref_bits #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  ld_en,
    input  logic [IDX_W-1:0]      ld_idx,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_idx,
    output logic [NUM_FRAMES-1:0] ref_vec
);
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_bit
        logic hit_set;
        logic hit_clr;
        assign hit_set = (set_en && set_idx == IDX_W'(i)) || (ld_en && ld_idx == IDX_W'(i));
        assign hit_clr = clr_en && clr_idx == IDX_W'(i);
        always_ff @(posedge clk) begin
            if (!rst_n)       ref_vec[i] <= 1'b0;
            else if (hit_set) ref_vec[i] <= 1'b1;   // set wins over clear
            else if (hit_clr) ref_vec[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/csel_hand.sv
module csel_hand #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] hand
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)    hand <= '0;
        else if (step) hand <= (hand == LAST) ? '0 : hand + 1'b1;
    end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             repl_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame
);
    import clock_sel_pkg::*;

    sel_state_e state_q, state_d;
    logic [NUM_FRAMES-1:0] ref_vec;
    logic [IDX_W-1:0]      hand;
    logic                  scanning;
    logic                  cur_bit;
    logic                  step;
    logic                  clr_en;
    logic                  ld_en;
    logic [IDX_W-1:0]      victim_q;

    csel_ref_bits #(.NUM_FRAMES(NUM_FRAMES)) i_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (acc_valid),
        .set_idx (acc_frame),
        .ld_en   (ld_en),
        .ld_idx  (hand),
        .clr_en  (clr_en),
        .clr_idx (hand),
        .ref_vec (ref_vec)
    );

    csel_hand #(.NUM_FRAMES(NUM_FRAMES)) i_hand (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .hand  (hand)
    );

    assign scanning = (state_q == ST_SCAN);
    assign cur_bit  = ref_vec[hand];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and scan controls
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        clr_en  = 1'b0;
        ld_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (repl_req) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                step = 1'b1;
                if (cur_bit) begin
                    clr_en = 1'b1;
                end else begin
                    ld_en   = 1'b1;
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     victim_q <= '0;
        else if (ld_en) victim_q <= hand;
    end

    // outputs
    always_comb begin
        victim_valid = (state_q == ST_REPORT);
        victim_frame = victim_q;
    end
endmodule

// File: rtl/csel_checker.sv
module csel_checker #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic [IDX_W-1:0]      acc_frame,
    input logic                  victim_valid,
    input logic [IDX_W-1:0]      victim_frame,
    input logic [IDX_W-1:0]      hand,
    input logic [NUM_FRAMES-1:0] ref_vec,
    input logic                  scanning
);
    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] h);
        return (h == IDX_W'(NUM_FRAMES - 1)) ? '0 : h + 1'b1;
    endfunction

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid); // R5

    AST_ACCESS_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ref_vec[$past(acc_frame)]); // R2

    AST_PASS_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && ref_vec[hand] && !(acc_valid && acc_frame == hand))
        |=> !ref_vec[$past(hand)]); // R4

    AST_SCAN_STEPS_HAND: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |=> hand == nxt($past(hand))); // R3

    AST_IDLE_HOLDS_HAND: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning |=> $stable(hand)); // R3

    AST_VICTIM_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> ref_vec[victim_frame]); // R6

    AST_HAND_AFTER_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> hand == nxt(victim_frame)); // R6
endmodule

bind clock_victim_sel csel_checker #(.NUM_FRAMES(NUM_FRAMES)) i_csel_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_frame    (acc_frame),
    .victim_valid (victim_valid),
    .victim_frame (victim_frame),
    .hand         (hand),
    .ref_vec      (ref_vec),
    .scanning     (scanning)
);

// File: tb/test_clock_victim_sel.sv
module test_clock_victim_sel;
    localparam int N = 8;
    localparam int W = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0;
    logic [W-1:0] acc_frame = '0;
    logic         repl_req = 1'b0;
    logic         victim_valid;
    logic [W-1:0] victim_frame;

    int total = 0;
    int bad = 0;
    bit mref [N];
    int mhand;

    always #10 clk = ~clk;   // 50 MHz

    clock_victim_sel #(.NUM_FRAMES(N)) i_clock_victim_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_frame    (acc_frame),
        .repl_req     (repl_req),
        .victim_valid (victim_valid),
        .victim_frame (victim_frame)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) mref[i] = 1'b0;
        mhand = 0;
    endtask

    task automatic do_access(input int f);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_frame = W'(f);
        @(negedge clk);
        acc_valid = 1'b0;
        mref[f] = 1'b1;
    endtask

    // coll >= 0: access that frame during the first examined cycle
    task automatic do_replace(input string req, input int coll);
        int h, n, exp_v, cnt;
        bit first;
        bit protect;
        h = mhand; n = 0; first = 1'b1;
        while (1) begin
            n++;
            protect = first && (coll == h);
            first = 1'b0;
            if (!mref[h]) break;
            if (!protect) mref[h] = 1'b0;
            h = (h + 1) % N;
        end
        exp_v = h;
        mref[h] = 1'b1;
        mhand = (h + 1) % N;
        if (coll >= 0) mref[coll] = 1'b1;

        @(negedge clk);
        repl_req = 1'b1;
        @(negedge clk);
        repl_req = 1'b0;
        if (coll >= 0) begin
            acc_valid = 1'b1;
            acc_frame = W'(coll);
        end
        cnt = 0;
        while (1) begin
            @(negedge clk);
            acc_valid = 1'b0;
            cnt++;
            if (victim_valid || cnt > 4 * N) break;
        end
        check(victim_valid, {req, " valid"}, int'(victim_valid), 1);
        check(int'(victim_frame) == exp_v, {req, " victim"}, int'(victim_frame), exp_v);
        check(cnt == n, {req, " latency"}, cnt, n);
        @(negedge clk);
        check(!victim_valid, "R5 pulse width", int'(victim_valid), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check(!victim_valid, "R1 valid low", int'(victim_valid), 0);
        do_replace("R1 first request", -1);

        // sweep start hand and bit pattern
        for (int s = 0; s < N; s++) begin
            for (int p = 0; p < (1 << N); p++) begin
                do_reset();
                for (int k = 0; k < s; k++) do_replace("R6 warm-up", -1);
                for (int f = 0; f < N; f++)
                    if (p[f]) do_access(f);   // R2
                if (p == (1 << N) - 1) do_replace("R7 full lap", -1);
                else                   do_replace("R3 R4 R5 sweep", -1);
                // R6: hand moved past victim; bit now set
                do_replace("R6 follow-up", -1);
            end
        end

        // R8: access on the frame being cleared keeps it set
        do_reset();
        for (int f = 0; f < N; f++) do_access(f);
        do_replace("R8 collision", 0);
        do_replace("R8 after collision", -1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule